// File: doc/BRIEF.md
# Triggered Zero-Suppressed Column Readout

This block is one readout region of a pixel matrix. Every pixel has a one-bit hit memory. While a strobe input is high, all pixels sample their discriminator inputs in the same clock cycle and keep any hit they see. When the strobe drops, a two-level priority encoder walks the stored hits and sends out only the addresses of the pixels that were hit, one word per accepted cycle, on a valid/ready stream. Empty pixels produce no words.

Each time an address is accepted downstream, the periphery clears that pixel's memory. Once no stored hit is left, the block sends a single end-of-event word and goes back to waiting for the next strobe. A strobe that arrives while an event is still being drained has no effect.

The matrix size is set by `ROWS` and `COLS`. `ROWS` must be a power of two, so that the address is the flat pixel index. A full-size region of 512 rows by 32 columns is reached through these parameters.

Top module: `readout_column`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid_o` is 0. Pixel memories are empty after reset.
- R2: While `strobe_i` is high and no event is being drained, every pixel whose `hit_i` bit is 1 in a sampled cycle stores a hit. Hits seen in different cycles of one window are combined as a logical OR.
- R3: A `hit_i` bit that is high only while `strobe_i` is low is not stored.
- R4: Pixel index is `col*ROWS + row`, carried as `hit_i` bit `col*ROWS+row`. A data word has `out_data_o[IDX_W-1:0]` equal to that index and the top bit `out_data_o[IDX_W]` equal to 0. Each stored hit is sent exactly once, and no unhit pixel is sent.
- R5: Addresses leave in ascending order: lowest column first, then lowest row within that column. This is the same as ascending flat index.
- R6: Draining starts after the strobe falls. A word is consumed on each rising edge where `out_valid_o` and `out_ready_i` are both 1. While `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` holds its value.
- R7: After the last address, one end-of-event word is sent, with top bit 1 and all other bits 0. In the cycle after that word is consumed, `out_valid_o` is 0.
- R8: A strobe window with no stored hits produces only the end-of-event word.
- R9: A strobe raised while an event is being drained neither stores hits nor starts a new event. After the current end-of-event word, `out_valid_o` stays 0.
- R10: The pixel whose address was consumed is cleared from the periphery, so it is not sent again in the same event or in later events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Capture window; the falling edge closes the event |
| hit_i | input | ROWS*COLS | Discriminator outputs, bit col*ROWS+row |
| out_ready_i | input | 1 | Downstream ready |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | IDX_W+1 | {end_of_event, pixel index} |

## Verification
The bench builds the block with `ROWS=8` and `COLS=4`. That gives a 32-pixel region whose full hit mask fits in one 32-bit table entry, so all-hit, single-corner, sparse and checkerboard patterns can be listed directly. With only eight rows per column, the stream crosses column boundaries after a few words, which exercises the step in the encoder from one column to the next. Over the full 32 pixels the bench also checks that the data is held during stalls and that the strobe is ignored during a drain.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_DRAIN = 2'd2
    } rdo_state_e;

    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pixel_matrix.sv
module pixel_matrix
    import rdo_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 8,
    localparam int NPIX  = ROWS * COLS,
    localparam int IDX_W = bits_for(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic [NPIX-1:0]  hit_i,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    output logic [NPIX-1:0]  mem_o
);

    logic [NPIX-1:0] mem_q;

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        logic sel_clr;
        assign sel_clr = clr_en_i && (clr_idx_i == IDX_W'(p));
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[p] <= 1'b0;
            else if (sel_clr)
                mem_q[p] <= 1'b0;
            else if (capture_i && hit_i[p])
                mem_q[p] <= 1'b1;
        end
    end

    assign mem_o = mem_q;

    AST_NO_SET_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> ((mem_q & ~$past(mem_q)) == '0)); // R3

    AST_CLEAR_EXACTLY_ONE: assert property (@(posedge clk) disable iff (rst)
        clr_en_i |=> ($countones($past(mem_q) & ~mem_q) == 1)); // R10

endmodule

// File: rtl/col_encoder.sv
module col_encoder
    import rdo_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 8,
    localparam int NPIX  = ROWS * COLS,
    localparam int ROW_W = bits_for(ROWS),
    localparam int COL_W = bits_for(COLS),
    localparam int IDX_W = bits_for(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIX-1:0]  req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [COLS-1:0]  col_any;
    logic [ROW_W-1:0] col_row [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] col_req;
        assign col_req = req_i[c*ROWS +: ROWS];
        always_comb begin
            col_any[c] = 1'b0;
            col_row[c] = '0;
            for (int r = ROWS - 1; r >= 0; r--) begin
                if (col_req[r]) begin
                    col_any[c] = 1'b1;
                    col_row[c] = ROW_W'(r);
                end
            end
        end
    end

    logic [COL_W-1:0] win_col;
    always_comb begin
        win_col = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (col_any[c])
                win_col = COL_W'(c);
        end
    end

    assign any_o = |col_any;
    assign idx_o = IDX_W'({win_col, col_row[win_col]});

    logic [NPIX-1:0] below_mask;
    assign below_mask = (NPIX'(1) << idx_o) - NPIX'(1);

    AST_ENC_PICKS_SET: assert property (@(posedge clk) disable iff (rst)
        any_o |-> req_i[idx_o]); // R4

    AST_ENC_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        any_o |-> ((req_i & below_mask) == '0)); // R5

    AST_ENC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !any_o |-> (req_i == '0)); // R8

endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
    import rdo_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             out_ready_i,
    output logic             capture_o,
    output logic             clr_en_o,
    output logic [IDX_W-1:0] clr_idx_o,
    output logic             out_valid_o,
    output logic [IDX_W:0]   out_data_o
);

    typedef struct packed {
        logic             eoe;
        logic [IDX_W-1:0] addr;
    } word_t;

    rdo_state_e state_q, state_d;
    word_t      word;
    logic       fire;

    assign capture_o   = (state_q != ST_DRAIN) && strobe_i;
    assign out_valid_o = (state_q == ST_DRAIN);
    assign fire        = out_valid_o && out_ready_i;
    assign clr_en_o    = fire && any_i;
    assign clr_idx_o   = idx_i;

    always_comb begin
        word.eoe  = !any_i;
        word.addr = any_i ? idx_i : '0;
    end
    assign out_data_o = word;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (strobe_i) state_d = ST_OPEN;
            ST_OPEN:  if (!strobe_i) state_d = ST_DRAIN;
            ST_DRAIN: if (fire && !any_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R6

    AST_EOE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (fire && out_data_o[IDX_W]) |=> !out_valid_o); // R7

    AST_NO_CAPTURE_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> !capture_o); // R9

endmodule

// File: rtl/readout_column.sv
module readout_column
    import rdo_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 8,
    localparam int NPIX  = ROWS * COLS,
    localparam int IDX_W = bits_for(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic [NPIX-1:0]  hit_i,
    input  logic             out_ready_i,
    output logic             out_valid_o,
    output logic [IDX_W:0]   out_data_o
);

    logic             capture;
    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic [NPIX-1:0]  mem;
    logic             any;
    logic [IDX_W-1:0] idx;

    pixel_matrix #(.ROWS(ROWS), .COLS(COLS)) u_mat (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .hit_i     (hit_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (clr_idx),
        .mem_o     (mem)
    );

    col_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
        .clk   (clk),
        .rst   (rst),
        .req_i (mem),
        .any_o (any),
        .idx_o (idx)
    );

    readout_ctrl #(.IDX_W(IDX_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (strobe_i),
        .any_i       (any),
        .idx_i       (idx),
        .out_ready_i (out_ready_i),
        .capture_o   (capture),
        .clr_en_o    (clr_en),
        .clr_idx_o   (clr_idx),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid_o); // R1

endmodule

// File: tb/sim_readout_column.sv
module sim_readout_column;

    localparam int ROWS  = 8;
    localparam int COLS  = 4;
    localparam int NPIX  = ROWS * COLS;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             strobe_i = 1'b0;
    logic [NPIX-1:0]  hit_i = '0;
    logic             out_ready_i = 1'b1;
    logic             out_valid_o;
    logic [IDX_W:0]   out_data_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    readout_column #(.ROWS(ROWS), .COLS(COLS)) u0 (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (strobe_i),
        .hit_i       (hit_i),
        .out_ready_i (out_ready_i),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o)
    );

    localparam int NVEC = 6;
    localparam logic [NPIX-1:0] VEC_MASK [NVEC] = '{
        32'h0000_0001, 32'h8000_0000, 32'hF0F0_0F0F,
        32'hFFFF_FFFF, 32'h0101_8001, 32'h0000_0000
    };
    localparam int VEC_STALL [NVEC] = '{0, 0, 3, 2, 0, 4};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [NPIX-1:0] m);
        @(negedge clk);
        strobe_i = 1'b1;
        hit_i    = m;
        @(negedge clk);
        strobe_i = 1'b0;
        hit_i    = '0;
    endtask

    task automatic drain(input logic [NPIX-1:0] exp_mask, input int stall_every, input string tag);
        logic [NPIX-1:0] rem;
        logic [IDX_W:0]  held;
        logic [IDX_W:0]  want;
        bit was_stall;
        bit done;
        int guard;
        rem = exp_mask;
        was_stall = 0;
        done = 0;
        guard = 0;
        held = '0;
        while (!done && guard < 400) begin
            @(negedge clk);
            guard++;
            out_ready_i = (stall_every == 0) ? 1'b1 : ((guard % stall_every) != 0);
            #1;
            if (was_stall)
                check(out_valid_o && out_data_o == held, "R6 stall hold", 32'(out_data_o), 32'(held));
            was_stall = 0;
            if (out_valid_o) begin
                if (!out_ready_i) begin
                    was_stall = 1;
                    held = out_data_o;
                end else begin
                    want = {1'b1, {IDX_W{1'b0}}};
                    for (int i = NPIX - 1; i >= 0; i--)
                        if (rem[i]) want = {1'b0, IDX_W'(i)};
                    if (!want[IDX_W]) rem[want[IDX_W-1:0]] = 1'b0;
                    else done = 1;
                    check(out_data_o == want,
                          want[IDX_W] ? {tag, " R7 eoe"} : {tag, " R4 R5 address"},
                          32'(out_data_o), 32'(want));
                end
            end
        end
        check(done, {tag, " R6 drain finished"}, 32'(done), 32'd1);
        @(negedge clk);
        out_ready_i = 1'b1;
        #1;
        check(!out_valid_o, {tag, " R7 idle after eoe"}, 32'(out_valid_o), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid_o, "R1 valid in reset", 32'(out_valid_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!out_valid_o, "R1 valid after reset", 32'(out_valid_o), 32'd0);

        // Empty after reset: first event has no hits (R1, R8)
        pulse('0);
        drain('0, 0, "R8 R1 empty after reset");

        // Table of patterns (R4 R5 R6 R10)
        for (int v = 0; v < NVEC; v++) begin
            pulse(VEC_MASK[v]);
            drain(VEC_MASK[v], VEC_STALL[v], $sformatf("vec%0d R10", v));
        end

        // Multi-cycle window ORs hits (R2)
        @(negedge clk);
        strobe_i = 1'b1; hit_i = 32'h0000_00F0;
        @(negedge clk);
        hit_i = 32'h0F00_0001;
        @(negedge clk);
        hit_i = 32'h0000_0000;
        @(negedge clk);
        strobe_i = 1'b0;
        drain(32'h0F00_00F1, 0, "R2 window or");

        // Hits outside the window are not stored (R3)
        @(negedge clk);
        hit_i = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        hit_i = '0;
        pulse('0);
        drain('0, 0, "R3 outside window");

        // Strobe during drain is ignored (R9)
        pulse(32'h0001_0100);
        @(negedge clk);
        out_ready_i = 1'b0;
        strobe_i = 1'b1;
        hit_i = 32'hFFFF_FFFF;
        @(negedge clk);
        strobe_i = 1'b0;
        hit_i = '0;
        drain(32'h0001_0100, 0, "R9 strobe in drain");
        repeat (3) begin
            @(negedge clk);
            #1;
            check(!out_valid_o, "R9 no restart", 32'(out_valid_o), 32'd0);
        end

        // Cleared pixels are not resent; a fresh single hit follows (R10)
        pulse(32'h4000_0000);
        drain(32'h4000_0000, 0, "R10 no stale");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule